// File: doc/BRIEF.md
# Lockable Battery RAM Access Gate

This block sits on the path from a host register bus to a 256-byte battery-backed RAM. The RAM has two 128-byte banks. Address bit 7 picks the bank. The block owns a 32-bit control register with two live bits: an upper-bank enable and a write-once lock over one eight-byte window of the lower bank. Every host access to the RAM passes through a combinational filter that uses the current register value. A blocked write never reaches the RAM write strobe, and a blocked read returns the filler byte 8'hFF.

The host reaches the control register through its own write port with byte enables. The first write whose byte 0 is enabled fixes the lock bit for good. Only the active-low reset clears that setting again. The RAM array sits outside the block and is read combinationally through `ram_rdata_i`.

Top module: `bram_gate`

## Requirements
- R1: After reset the control register reads 32'h0, so the upper bank is disabled and the window is unlocked.
- R2: Bit 2 of the control register is the upper-bank enable. Every control write with `cfg_be_i[0]`=1 loads it from `cfg_wdata_i[2]`, and it reads back at bit 2.
- R3: While bit 2 is 0, a host access with `host_addr_i[7]`=1 asserts neither `ram_we_o` nor `ram_re_o`, and a read returns 8'hFF.
- R4: While bit 2 is 1, upper-bank writes reach the RAM and upper-bank reads return the stored byte.
- R5: While bit 3 (the lock) is 1, writes to addresses 8'h38–8'h3F are dropped and reads from them return 8'hFF.
- R6: While the lock is 0, addresses 8'h38–8'h3F behave like any other lower-bank location.
- R7: The lock is loaded from `cfg_wdata_i[3]` only by the first control write with `cfg_be_i[0]`=1 after reset. Later writes leave it unchanged until `rst_ni` is asserted.
- R8: Control register bits 1:0 and 31:4 always read 0, and writing ones to them has no effect.
- R9: A control write with `cfg_be_i[0]`=0 changes neither bit 2 nor bit 3, and it does not consume the write-once chance.
- R10: A control write takes effect at the clock edge that samples it. A RAM access in the same cycle is filtered by the old value, and the new value applies from the next cycle.
- R11: Lower-bank addresses outside 8'h38–8'h3F always pass, whatever the lock and the enable are set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_be_i | input | 4 | Control write byte enables |
| cfg_wdata_i | input | 32 | Control write data |
| cfg_rdata_o | output | 32 | Control register read value |
| host_req_i | input | 1 | Host RAM access request |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 8 | Host RAM byte address |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Read byte, or 8'hFF when blocked or idle |
| ram_addr_o | output | 8 | RAM address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| ram_wdata_o | output | 8 | RAM write byte |
| ram_rdata_i | input | 8 | RAM read byte, combinational from the array |

## Verification
RAM strobes and host read data are combinational, so the bench checks them in the same cycle the request is driven, 2 ns after the falling edge. A control write becomes visible at `cfg_rdata_o` and in the gating one cycle later, after the rising edge that registers it. The reference model therefore updates its register copy only after it has compared that cycle. A RAM write shows up in a read no earlier than the next cycle, and the model applies written bytes on the same one-cycle delay.

// File: rtl/bram_gate_pkg.sv
package bram_gate_pkg;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned ENA_POS  = 2;
  localparam int unsigned LOCK_POS = 3;

  typedef enum logic [1:0] {
    RGN_LOWER_OPEN = 2'd0,
    RGN_LOWER_WIN  = 2'd1,
    RGN_UPPER      = 2'd2
  } region_e;

  typedef struct packed {
    logic upper_en;
    logic lock;
  } ctrl_t;
endpackage

// File: rtl/bram_gate_cfg.sv
module bram_gate_cfg
  import bram_gate_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [W/8-1:0] be_i,
  input  logic [W-1:0]   wdata_i,
  output ctrl_t          ctrl_o,
  output logic [W-1:0]   rdata_o
);
  localparam int unsigned BE_W      = W / 8;
  localparam int unsigned ENA_BYTE  = ENA_POS / 8;
  localparam int unsigned LOCK_BYTE = LOCK_POS / 8;

  logic upper_en_q, lock_q, written_q;
  logic ena_hit, lock_hit;

  assign ena_hit  = we_i && be_i[ENA_BYTE];
  assign lock_hit = we_i && be_i[LOCK_BYTE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_en_q <= 1'b0;
      lock_q     <= 1'b0;
      written_q  <= 1'b0;
    end else begin
      if (ena_hit) upper_en_q <= wdata_i[ENA_POS];
      // write-once: only the first targeting write lands
      if (lock_hit && !written_q) begin
        lock_q    <= wdata_i[LOCK_POS];
        written_q <= 1'b1;
      end
    end
  end

  assign ctrl_o.upper_en = upper_en_q;
  assign ctrl_o.lock     = lock_q;

  for (genvar i = 0; i < W; i++) begin : g_rd
    if (i == ENA_POS) begin : g_ena
      assign rdata_o[i] = upper_en_q;
    end else if (i == LOCK_POS) begin : g_lock
      assign rdata_o[i] = lock_q;
    end else begin : g_resv
      assign rdata_o[i] = 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wdata_i, be_i, BE_W[0]};
endmodule

// File: rtl/bram_gate_decode.sv
module bram_gate_decode
  import bram_gate_pkg::*;
#(
  parameter int unsigned          ADDR_W = 8,
  parameter logic [ADDR_W-1:0]    WIN_LO = 8'h38,
  parameter logic [ADDR_W-1:0]    WIN_HI = 8'h3F
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);
  localparam int unsigned BANK_BIT = ADDR_W - 1;

  logic upper, in_win;
  assign upper  = addr_i[BANK_BIT];
  assign in_win = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);

  always_comb begin
    if (upper)       region_o = RGN_UPPER;
    else if (in_win) region_o = RGN_LOWER_WIN;
    else             region_o = RGN_LOWER_OPEN;
  end
endmodule

// File: rtl/bram_gate_filter.sv
module bram_gate_filter
  import bram_gate_pkg::*;
#(
  parameter int unsigned       ADDR_W = 8,
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL   = '1
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  region_e           region_i,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic allow;

  always_comb begin
    unique case (region_i)
      RGN_UPPER:     allow = ctrl_i.upper_en;
      RGN_LOWER_WIN: allow = !ctrl_i.lock;
      default:       allow = 1'b1;
    endcase
  end

  assign ram_addr_o  = addr_i;
  assign ram_wdata_o = wdata_i;
  assign ram_we_o    = req_i && we_i && allow;
  assign ram_re_o    = req_i && !we_i && allow;
  assign rdata_o     = ram_re_o ? ram_rdata_i : FILL;
endmodule

// File: rtl/bram_gate.sv
module bram_gate
  import bram_gate_pkg::*;
#(
  parameter int unsigned          ADDR_W = 8,
  parameter int unsigned          DATA_W = 8,
  parameter logic [ADDR_W-1:0]    WIN_LO = 8'h38,
  parameter logic [ADDR_W-1:0]    WIN_HI = 8'h3F,
  parameter logic [DATA_W-1:0]    FILL   = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  ctrl_t   ctrl;
  region_e region;

  bram_gate_cfg #(.W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .be_i   (cfg_be_i),
    .wdata_i(cfg_wdata_i),
    .ctrl_o (ctrl),
    .rdata_o(cfg_rdata_o)
  );

  bram_gate_decode #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_dec (
    .addr_i  (host_addr_i),
    .region_o(region)
  );

  bram_gate_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL(FILL)) u_flt (
    .req_i      (host_req_i),
    .we_i       (host_we_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .region_i   (region),
    .ctrl_i     (ctrl),
    .ram_rdata_i(ram_rdata_i),
    .ram_addr_o (ram_addr_o),
    .ram_we_o   (ram_we_o),
    .ram_re_o   (ram_re_o),
    .ram_wdata_o(ram_wdata_o),
    .rdata_o    (host_rdata_o)
  );
endmodule

// File: rtl/bram_gate_chk.sv
module bram_gate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_we_i,
  input logic [3:0]  cfg_be_i,
  input logic [31:0] cfg_wdata_i,
  input logic [31:0] cfg_rdata_o,
  input logic        host_req_i,
  input logic        host_we_i,
  input logic [7:0]  host_addr_i,
  input logic [7:0]  host_wdata_i,
  input logic [7:0]  host_rdata_o,
  input logic [7:0]  ram_addr_o,
  input logic        ram_we_o,
  input logic        ram_re_o,
  input logic [7:0]  ram_wdata_o,
  input logic [7:0]  ram_rdata_i
);
  logic in_win;
  assign in_win = host_addr_i >= 8'h38 && host_addr_i <= 8'h3F;

  p_upper_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && host_addr_i[7] && !cfg_rdata_o[2] |-> !ram_we_o && !ram_re_o && host_rdata_o == 8'hFF);

  p_upper_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_we_i && host_addr_i[7] && cfg_rdata_o[2] |-> ram_re_o && host_rdata_o == ram_rdata_i);

  p_win_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && in_win && cfg_rdata_o[3] |-> !ram_we_o && !ram_re_o);

  p_lock_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_rdata_o[3]) |-> cfg_rdata_o[3]);

  p_resv_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & ~32'h0000_000C) == 32'h0);

  p_no_be_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !cfg_be_i[0] |=> $stable(cfg_rdata_o));

  p_open_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && host_we_i && !host_addr_i[7] && !in_win |->
      ram_we_o && ram_addr_o == host_addr_i && ram_wdata_o == host_wdata_i);
endmodule

bind bram_gate bram_gate_chk u_chk (.*);

// File: tb/bram_gate_bench.sv
`timescale 1ns/1ps
module bram_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wd = '0;
  logic [31:0] cfg_rd;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0, wd = '0, rd;
  logic [7:0]  ram_addr, ram_wdata, ram_rdata;
  logic        ram_we, ram_re;

  logic [7:0] ram_q   [256];
  logic [7:0] ref_mem [256];
  bit ref_ena, ref_lock, ref_written;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bram_gate u_bram_gate (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wd), .cfg_rdata_o(cfg_rd),
    .host_req_i(req), .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wd),
    .host_rdata_o(rd), .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_re_o(ram_re),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  assign ram_rdata = ram_q[ram_addr];
  always @(posedge clk) if (ram_we) ram_q[ram_addr] <= ram_wdata;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, compare combinational results, advance model
  task automatic cyc(bit r, bit w, logic [7:0] a, logic [7:0] d,
                     bit cw, logic [3:0] cb, logic [31:0] cd, string tag);
    bit upper, win, allow, exp_we;
    @(negedge clk);
    req = r; we = w; addr = a; wd = d; cfg_we = cw; cfg_be = cb; cfg_wd = cd;
    #2;
    chk({tag, " R8 cfg"}, cfg_rd, {28'h0, ref_lock, ref_ena, 2'b00});
    upper  = a[7];
    win    = !upper && a >= 8'h38 && a <= 8'h3F;
    allow  = upper ? ref_ena : (win ? !ref_lock : 1'b1);
    exp_we = r && w && allow;
    chk({tag, " we"}, {31'h0, ram_we}, {31'h0, exp_we});
    if (r && !w) chk({tag, " rd"}, {24'h0, rd}, {24'h0, allow ? ref_mem[a] : 8'hFF});
    if (exp_we) ref_mem[a] = d;
    if (cw && cb[0]) begin
      ref_ena = cd[2];
      if (!ref_written) begin
        ref_lock = cd[3];
        ref_written = 1'b1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 0; cfg_we = 0;
    ref_ena = 0; ref_lock = 0; ref_written = 0;
    #2;
    chk("R1 reset cfg", cfg_rd, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram_q[i] = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (2) @(posedge clk);
    do_reset();
    cyc(0, 0, 0, 0, 0, 0, 0, "R1 idle");
    // lower open and unlocked window
    cyc(1, 1, 8'h10, 8'hA1, 0, 0, 0, "R11 wr");
    cyc(1, 0, 8'h10, 0, 0, 0, 0, "R11 rd");
    for (int a = 8'h38; a <= 8'h3F; a++) cyc(1, 1, 8'(a), 8'(a + 3), 0, 0, 0, "R6 wr");
    for (int a = 8'h38; a <= 8'h3F; a++) cyc(1, 0, 8'(a), 0, 0, 0, 0, "R6 rd");
    // upper disabled
    cyc(1, 1, 8'h90, 8'h11, 0, 0, 0, "R3 wr");
    cyc(1, 0, 8'h90, 0, 0, 0, 0, "R3 rd");
    cyc(1, 0, 8'hFF, 0, 0, 0, 0, "R3 rd top");
    // no byte-0 enable: ignored, no write-once consumed
    cyc(0, 0, 0, 0, 1, 4'b1110, 32'hFFFF_FFFF, "R9 write");
    cyc(1, 0, 8'h3A, 0, 0, 0, 0, "R9 after");
    // set enable+lock with reserved ones, window write in same cycle passes
    cyc(1, 1, 8'h3C, 8'hC3, 1, 4'hF, 32'hFFFF_FFFF, "R10 same cycle");
    cyc(1, 1, 8'h3C, 8'h77, 0, 0, 0, "R5 wr drop");
    cyc(1, 0, 8'h3C, 0, 0, 0, 0, "R5 rd");
    cyc(1, 0, 8'h38, 0, 0, 0, 0, "R5 rd lo");
    cyc(1, 0, 8'h3F, 0, 0, 0, 0, "R5 rd hi");
    cyc(1, 0, 8'h37, 0, 0, 0, 0, "R11 below");
    cyc(1, 0, 8'h40, 0, 0, 0, 0, "R11 above");
    cyc(1, 0, 8'h90, 0, 0, 0, 0, "R4 rd");
    cyc(1, 1, 8'hA0, 8'h5E, 0, 0, 0, "R4 wr");
    cyc(1, 0, 8'hA0, 0, 0, 0, 0, "R4 rd back");
    // clear attempt: enable drops, lock holds
    cyc(0, 0, 0, 0, 1, 4'h1, 32'h0, "R7 clear try");
    cyc(1, 0, 8'hA0, 0, 0, 0, 0, "R2 disabled");
    cyc(1, 0, 8'h3C, 0, 0, 0, 0, "R7 still locked");
    cyc(0, 0, 0, 0, 1, 4'h1, 32'h4, "R2 re-enable");
    cyc(1, 0, 8'hA0, 0, 0, 0, 0, "R2 enabled");
    for (int a = 0; a < 256; a += 7) cyc(1, 0, 8'(a), 0, 0, 0, 0, "R11 sweep");
    // reset clears lock; first write of zero burns the once
    do_reset();
    cyc(1, 0, 8'h3C, 0, 0, 0, 0, "R7 after reset");
    cyc(0, 0, 0, 0, 1, 4'h1, 32'h0, "R7 first zero");
    cyc(0, 0, 0, 0, 1, 4'h1, 32'h8, "R7 late set");
    cyc(1, 1, 8'h3D, 8'h99, 0, 0, 0, "R7 win open");
    cyc(1, 0, 8'h3D, 0, 0, 0, 0, "R6 rd");
    cyc(0, 0, 0, 0, 0, 0, 0, "R1 idle end");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule